// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break and Overrun Handling

This block receives an asynchronous serial line. It samples the line on a sample-enable pulse that runs at sixteen times the bit rate. It looks for a start bit, gathers data bits with the least significant bit first, and checks the stop bit. Each finished character goes into a holding register, and a ready flag tells the host that a character is waiting. The host takes the character by pulsing a read strobe.

A character can finish while the previous one is still unread. The block then raises an overrun flag that stays set. The unread byte in the holding register is left untouched. A line held low through a whole frame is reported as a break. The break flag drops by itself once the line has stayed at mark for one full bit time. The end of a break never produces a character. Reception starts again on the next real start bit, with no reset and no reprogramming.

Top module: `async_rx`

## Requirements
- R1: After reset, `rx_ready`, `overrun` and `break_det` are all low.
- R2: A frame is one low start bit, DATA_BITS data bits sent least significant bit first, and one high stop bit, each bit lasting 16 sample ticks. Every byte value 0x00 to 0xFF sent this way shows up on `rx_data` with `rx_ready` high before the end of its stop bit.
- R3: A start bit is accepted only if the line is still low at the mid-bit sample, 8 ticks after the falling edge is seen. A low pulse of less than half a bit delivers no character.
- R4: `rx_ready` goes low in the same clock cycle in which `rd_strobe` is high. It stays low afterwards until a new character completes.
- R5: If a character completes while `rx_ready` is high, `overrun` is set on the next clock. The held byte on `rx_data` does not change.
- R6: `overrun` stays set through data reads. Only a pulse on `err_clr` clears it.
- R7: A frame whose data bits are all zero, and whose stop-bit sample finds the line low, sets `break_det` and does not raise `rx_ready`. A high glitch shorter than one bit time during the break leaves `break_det` set.
- R8: `break_det` clears by itself after the line has been high for 16 consecutive ticks.
- R9: No character is delivered when a break ends. The next well-formed frame is received correctly without a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_16x | input | 1 | Sample enable pulse, 16 per bit time |
| rxd | input | 1 | Serial line, high is mark (idle) |
| rd_strobe | input | 1 | Host read of the data register, one cycle per read |
| err_clr | input | 1 | Pulse that clears the overrun flag |
| rx_data | output | DATA_BITS | Held received character |
| rx_ready | output | 1 | A character is waiting to be read |
| overrun | output | 1 | A character arrived while the previous one was unread (sticky) |
| break_det | output | 1 | The line is in a break condition |

## Verification
A character becomes ready at the stop-bit centre sample. The line first passes through two synchronizer stages. The shifter then takes one clock to issue its completion pulse, and the holding register one more clock to latch it. That puts the ready flag about half a bit before the end of the stop bit. The bench therefore checks data, ready and overrun a few clocks after the whole frame has been driven.

The ready flag's clearing is checked in the middle of the cycle in which the read strobe is held. `break_det` is checked two bit times after the line is released, which is later than the 16 high ticks plus synchronizer delay it needs. The absence of a phantom character is then confirmed after more than a full frame of idle line.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_STOP,
      ST_BRK
   } rx_state_t;
endpackage

// File: rtl/async_rx_sync.sv
module async_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2+1-1:0], d};
         end
         assign q = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/async_rx_frame.sv
module async_rx_frame
   import async_rx_pkg::*;
#(
   parameter int OVERSAMPLE = 16,
   parameter int DATA_BITS  = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 line,
   output logic                 char_done,
   output logic [DATA_BITS-1:0] char_byte,
   output logic                 in_break
);
   localparam int CNT_W = $clog2(OVERSAMPLE);
   localparam int IDX_W = $clog2(DATA_BITS);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);
   localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVERSAMPLE / 2 - 1);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BITS - 1);

   rx_state_t            state_q;
   logic [CNT_W-1:0]     cnt_q;
   logic [IDX_W-1:0]     idx_q;
   logic [DATA_BITS-1:0] shift_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         idx_q     <= '0;
         shift_q   <= '0;
         char_done <= 1'b0;
      end else begin
         char_done <= 1'b0;
         if (tick) begin
            unique case (state_q)
               ST_IDLE: begin
                  cnt_q <= '0;
                  if (!line) state_q <= ST_START;
               end
               ST_START: begin
                  if (cnt_q == CNT_MID) begin
                     cnt_q <= '0;
                     idx_q <= '0;
                     state_q <= line ? ST_IDLE : ST_DATA;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_DATA: begin
                  if (cnt_q == CNT_LAST) begin
                     cnt_q   <= '0;
                     shift_q <= {line, shift_q[DATA_BITS-1:1]};
                     idx_q   <= idx_q + 1'b1;
                     if (idx_q == IDX_LAST) state_q <= ST_STOP;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_STOP: begin
                  if (cnt_q == CNT_LAST) begin
                     cnt_q <= '0;
                     if (!line && shift_q == '0) begin
                        state_q <= ST_BRK;
                     end else begin
                        char_done <= 1'b1;
                        state_q   <= ST_IDLE;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_BRK: begin
                  if (!line) begin
                     cnt_q <= '0;
                  end else if (cnt_q == CNT_LAST) begin
                     cnt_q   <= '0;
                     state_q <= ST_IDLE;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign char_byte = shift_q;
   assign in_break  = (state_q == ST_BRK);
endmodule

// File: rtl/async_rx_hold.sv
module async_rx_hold #(
   parameter int DATA_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 char_done,
   input  logic [DATA_BITS-1:0] char_byte,
   input  logic                 rd_strobe,
   input  logic                 err_clr,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 rx_ready,
   output logic                 overrun
);
   logic                 rdy_q;
   logic                 ovr_q;
   logic [DATA_BITS-1:0] data_q;
   logic                 slot_free;

   assign slot_free = !rdy_q || rd_strobe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_q  <= 1'b0;
         ovr_q  <= 1'b0;
         data_q <= '0;
      end else begin
         if (char_done && slot_free) begin
            data_q <= char_byte;
            rdy_q  <= 1'b1;
         end else if (rd_strobe) begin
            rdy_q  <= 1'b0;
         end
         if (char_done && !slot_free) ovr_q <= 1'b1;
         else if (err_clr)            ovr_q <= 1'b0;
      end
   end

   assign rx_data  = data_q;
   assign rx_ready = rdy_q && !rd_strobe;
   assign overrun  = ovr_q;
endmodule

// File: rtl/async_rx.sv
module async_rx #(
   parameter int OVERSAMPLE  = 16,
   parameter int DATA_BITS   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_16x,
   input  logic                 rxd,
   input  logic                 rd_strobe,
   input  logic                 err_clr,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 rx_ready,
   output logic                 overrun,
   output logic                 break_det
);
   generate
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0)
         $error("OVERSAMPLE must be even and at least 4");
      if (DATA_BITS < 5 || DATA_BITS > 9)
         $error("DATA_BITS must be between 5 and 9");
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4)
         $error("SYNC_STAGES must be between 0 and 4");
   endgenerate

   logic                 line_s;
   logic                 frame_done;
   logic [DATA_BITS-1:0] frame_byte;

   async_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rxd),
      .q     (line_s)
   );

   async_rx_frame #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_16x),
      .line      (line_s),
      .char_done (frame_done),
      .char_byte (frame_byte),
      .in_break  (break_det)
   );

   async_rx_hold #(.DATA_BITS(DATA_BITS)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .char_done (frame_done),
      .char_byte (frame_byte),
      .rd_strobe (rd_strobe),
      .err_clr   (err_clr),
      .rx_data   (rx_data),
      .rx_ready  (rx_ready),
      .overrun   (overrun)
   );
endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk #(
   parameter int DATA_BITS = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 rd_strobe,
   input logic                 err_clr,
   input logic                 line_s,
   input logic                 char_done,
   input logic [DATA_BITS-1:0] rx_data,
   input logic                 rx_ready,
   input logic                 overrun,
   input logic                 break_det
);
   assert_rd_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe && !char_done |=> !rx_ready);

   assert_ovr_flagged_R5: assert property (@(posedge clk) disable iff (!rst_n)
      char_done && rx_ready |=> overrun);

   assert_held_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready |=> $stable(rx_data));

   assert_ovr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      overrun && !err_clr |=> overrun);

   assert_no_char_in_break_R9: assert property (@(posedge clk) disable iff (!rst_n)
      break_det |-> !char_done);

   assert_break_ends_on_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(break_det) |-> $past(line_s));
endmodule

bind async_rx async_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_strobe (rd_strobe),
   .err_clr   (err_clr),
   .line_s    (line_s),
   .char_done (frame_done),
   .rx_data   (rx_data),
   .rx_ready  (rx_ready),
   .overrun   (overrun),
   .break_det (break_det)
);

// File: tb/async_rx_tb.sv
module async_rx_tb;
   localparam int BIT_CLK = 32;   // 16 ticks, one tick every 2 clocks

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_16x = 1'b0;
   logic       rxd = 1'b1;
   logic       rd_strobe = 1'b0;
   logic       err_clr = 1'b0;
   logic [7:0] rx_data;
   logic       rx_ready;
   logic       overrun;
   logic       break_det;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   initial forever begin
      @(negedge clk);
      tick_16x = ~tick_16x;
   end

   async_rx u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_16x  (tick_16x),
      .rxd       (rxd),
      .rd_strobe (rd_strobe),
      .err_clr   (err_clr),
      .rx_data   (rx_data),
      .rx_ready  (rx_ready),
      .overrun   (overrun),
      .break_det (break_det)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic hold_line(input logic v, input int clocks);
      rxd = v;
      repeat (clocks) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] b, input logic stop);
      hold_line(1'b0, BIT_CLK);
      for (int i = 0; i < 8; i++) hold_line(b[i], BIT_CLK);
      hold_line(stop, BIT_CLK);
      rxd = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic read_byte(input logic [7:0] exp, input string req);
      rd_strobe = 1'b1;
      #1;
      check({req, " data on read"}, rx_data, exp);
      check("R4 ready low during read", rx_ready, 0);
      @(negedge clk);
      rd_strobe = 1'b0;
      #1;
      check("R4 ready stays low after read", rx_ready, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (BIT_CLK) @(negedge clk);

      // R1 reset state
      check("R1 ready", rx_ready, 0);
      check("R1 overrun", overrun, 0);
      check("R1 break", break_det, 0);

      // R2 / R4: sweep every byte value
      for (int v = 0; v < 256; v++) begin
         send_frame(8'(v), 1'b1);
         check("R2 ready", rx_ready, 1);
         check("R2 data", rx_data, v);
         read_byte(8'(v), "R2");
         check("R5 no overrun in sweep", overrun, 0);
      end

      // R3: short low pulse is rejected
      hold_line(1'b0, 8);
      hold_line(1'b1, 12 * BIT_CLK);
      check("R3 glitch gives no char", rx_ready, 0);
      check("R3 glitch no break", break_det, 0);

      // R5 / R6: overrun keeps held byte
      send_frame(8'hA5, 1'b1);
      check("R5 first ready", rx_ready, 1);
      check("R5 no overrun yet", overrun, 0);
      send_frame(8'h3C, 1'b1);
      check("R5 overrun set", overrun, 1);
      check("R5 held byte intact", rx_data, 8'hA5);
      check("R5 still ready", rx_ready, 1);
      read_byte(8'hA5, "R5");
      check("R6 overrun survives read", overrun, 1);
      repeat (BIT_CLK) @(negedge clk);
      check("R6 overrun still set", overrun, 1);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      #1;
      check("R6 overrun cleared", overrun, 0);

      // R7 / R8 / R9: break
      hold_line(1'b0, 30 * BIT_CLK);
      check("R7 break set", break_det, 1);
      check("R7 no ready in break", rx_ready, 0);
      hold_line(1'b1, 8);
      hold_line(1'b0, 2 * BIT_CLK);
      check("R7 short mark keeps break", break_det, 1);
      check("R9 no char from glitch", rx_ready, 0);
      hold_line(1'b1, 2 * BIT_CLK);
      check("R8 break self-clears", break_det, 0);
      hold_line(1'b1, 12 * BIT_CLK);
      check("R9 no phantom char", rx_ready, 0);
      check("R9 no overrun", overrun, 0);
      send_frame(8'h5A, 1'b1);
      check("R9 recovery ready", rx_ready, 1);
      check("R9 recovery data", rx_data, 8'h5A);
      read_byte(8'h5A, "R9");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule